// File: doc/BRIEF.md
# Link Packet Framer with Start-Token Alignment

This block turns a stream of transaction packets into link packets on a wide output bus. Packets arrive one 32-bit dword per cycle, with a flag on the final dword. The framer puts a 4-byte start token ahead of each packet. It then forwards the header and payload dwords unchanged and appends a 4-byte link CRC. Each dword goes into one slot of a 16-byte output word, with per-byte enables and a valid/ready handshake.

Before each start token, the framer can insert zero-valued logical idle dwords. A two-bit setting selects how far apart start tokens must be aligned. The block also accepts 6-byte link control packets. Each one is widened with two zero bytes into an 8-byte slot that starts on a dword boundary. Control packets only go out between transaction packets, and they win over a waiting transaction packet. If no packet is waiting and the current output word is only partly filled, the framer sends that word with enables only on the filled dwords.

The stream position is the count of dword slots placed on the output bus since reset. It wraps every 64 bytes and includes the disabled slots of partly filled words. The first stream byte of a dword is held in bits [7:0] of that dword. Dword slot k of an output word occupies bits [32k+31:32k].

Top module: `lpf_link_framer`

## Requirements
- R1: While reset is held and on the first edge after reset is released, `out_valid`, `tlp_ready` and `ctrl_ready` are low.
- R2: Every transaction packet starts with one dword equal to the parameter `START_TOKEN` (default 32'h0000_A5F0), with all four byte enables set.
- R3: The header and payload dwords follow the start token unchanged and in arrival order. This holds for a 12- or 16-byte header and for payloads of up to 1024 bytes, including 128, 256 and 512 bytes.
- R4: The dword after the final packet dword is the link CRC. The CRC is computed over header and payload with polynomial 0x04C11DB7 and an all-ones initial value. Each byte is processed in stream order, most significant bit first, and the register is bit-inverted before sending. Bit i of the inverted register is bit i of the dword.
- R5: `cfg_align` sets the start-token alignment: 0 = none, 1 = 16 bytes, 2 = 32 bytes, 3 = 64 bytes. Zero dwords with full enables are inserted before a start token until its stream position is a multiple of the setting. With setting 0, packets are packed back to back.
- R6: A control packet is sent as two dwords starting on a dword boundary. The first dword is `ctrl_data[31:0]`; the second dword is `{16'h0, ctrl_data[47:32]}`, so byte i of the packet comes from `ctrl_data[8i+7:8i]`. `ctrl_ready` is high for the cycle in which the second dword is taken.
- R7: If a control packet and a transaction packet are both waiting between packets, the control packet is sent first. A control packet never appears inside a transaction packet; a control packet raised mid-packet goes out right after that packet's link CRC.
- R8: Every output word has byte enables that are a contiguous run from byte 0, in whole dwords. A word that is full has all 16 enables set.
- R9: When no packet is waiting and the current word is partly filled, that word is sent. Unfilled dwords carry zero data and cleared enables, and the next dword goes into slot 0 of a new word.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_be` hold; no dword is lost or repeated under back-pressure.
- R11: Cycles in which `tlp_valid` is low inside a packet add nothing to the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_align | input | 2 | Start-token alignment setting (R5) |
| tlp_valid | input | 1 | Transaction dword available |
| tlp_ready | output | 1 | Transaction dword taken this cycle |
| tlp_data | input | 32 | Transaction header/payload dword |
| tlp_last | input | 1 | Marks the final dword of a packet |
| ctrl_valid | input | 1 | Control packet waiting |
| ctrl_ready | output | 1 | Control packet taken this cycle |
| ctrl_data | input | 48 | Six control bytes, byte 0 in bits [7:0] |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 128 | Output word, dword slot 0 in bits [31:0] |
| out_be | output | 16 | Byte enables for `out_data` |

## Verification
The assertions take for granted that upstream sources follow a valid/ready discipline: a raised `tlp_valid` or `ctrl_valid` keeps its data and `tlp_last` until accepted. They also assume `cfg_align` changes only while no packet is in flight. The bench drives every input at the falling edge and lowers a valid only after its handshake. It sets the alignment only between scenarios, after the previous stream has fully drained. Gaps inside packets come only from deliberately dropping `tlp_valid` between dwords, never while a dword is waiting.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PAD,
      ST_SOP,
      ST_BODY,
      ST_CRC,
      ST_CTL_A,
      ST_CTL_B
   } lpf_state_e;

   localparam int DW_BITS   = 32;
   localparam int DW_BYTES  = DW_BITS / 8;
   localparam int CTL_BYTES = 6;

   // one byte through a left-shifting CRC register, MSB of the byte first
   function automatic logic [31:0] crc32_byte(input logic [31:0] c,
                                              input logic [7:0]  b,
                                              input logic [31:0] poly);
      logic [31:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ poly;
         else              r = {r[30:0], 1'b0};
      end
      return r;
   endfunction

endpackage

// File: rtl/lpf_crc32.sv
module lpf_crc32 #(
   parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [31:0] din,
   output logic [31:0] crc_q
);
   import lpf_pkg::*;

   logic [31:0] chain [0:DW_BYTES];

   assign chain[0] = crc_q;

   generate
      for (genvar b = 0; b < DW_BYTES; b++) begin : g_byte
         assign chain[b+1] = crc32_byte(chain[b], din[8*b +: 8], POLY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '1;
      else if (clr) crc_q <= '1;
      else if (en)  crc_q <= chain[DW_BYTES];
   end

endmodule

// File: rtl/lpf_seq.sv
module lpf_seq #(
   parameter int          LANES       = 4,
   parameter logic [31:0] START_TOKEN = 32'h0000_A5F0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cfg_align,
   input  logic        tlp_valid,
   output logic        tlp_ready,
   input  logic [31:0] tlp_data,
   input  logic        tlp_last,
   input  logic        ctrl_valid,
   output logic        ctrl_ready,
   input  logic [47:0] ctrl_data,
   input  logic        adv,
   input  logic [31:0] crc_q,
   output logic        crc_clr,
   output logic        crc_en,
   output logic        push,
   output logic [31:0] push_dw,
   output logic        flush
);
   import lpf_pkg::*;

   localparam int LANE_W = $clog2(LANES);
   localparam int POS_W  = LANE_W + 2;

   lpf_state_e       st_q, st_d;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] align_mask;
   logic             aligned_now, aligned_next;

   always_comb begin
      case (cfg_align)
         2'd0:    align_mask = '0;
         2'd1:    align_mask = POS_W'(LANES - 1);
         2'd2:    align_mask = POS_W'(2 * LANES - 1);
         default: align_mask = '1;
      endcase
   end

   assign aligned_now  = (pos_q & align_mask) == '0;
   assign aligned_next = ((pos_q + POS_W'(1)) & align_mask) == '0;

   always_comb begin
      st_d       = st_q;
      push       = 1'b0;
      push_dw    = '0;
      tlp_ready  = 1'b0;
      ctrl_ready = 1'b0;
      crc_clr    = 1'b0;
      crc_en     = 1'b0;
      flush      = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (ctrl_valid)                         st_d  = ST_CTL_A;
            else if (tlp_valid)                     st_d  = aligned_now ? ST_SOP : ST_PAD;
            else if (pos_q[LANE_W-1:0] != '0)       flush = 1'b1;
         end
         ST_PAD: begin
            if (adv) begin
               push = 1'b1;
               if (aligned_next) st_d = ST_SOP;
            end
         end
         ST_SOP: begin
            if (adv) begin
               push    = 1'b1;
               push_dw = START_TOKEN;
               crc_clr = 1'b1;
               st_d    = ST_BODY;
            end
         end
         ST_BODY: begin
            tlp_ready = adv;
            if (adv && tlp_valid) begin
               push    = 1'b1;
               push_dw = tlp_data;
               crc_en  = 1'b1;
               if (tlp_last) st_d = ST_CRC;
            end
         end
         ST_CRC: begin
            if (adv) begin
               push    = 1'b1;
               push_dw = ~crc_q;
               st_d    = ST_IDLE;
            end
         end
         ST_CTL_A: begin
            if (adv) begin
               push    = 1'b1;
               push_dw = ctrl_data[31:0];
               st_d    = ST_CTL_B;
            end
         end
         ST_CTL_B: begin
            if (adv) begin
               push       = 1'b1;
               push_dw    = {16'h0000, ctrl_data[47:32]};
               ctrl_ready = 1'b1;
               st_d       = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         pos_q <= '0;
      end else begin
         st_q <= st_d;
         if (push)       pos_q <= pos_q + POS_W'(1);
         else if (flush) pos_q <= (pos_q | POS_W'(LANES - 1)) + POS_W'(1);
      end
   end

endmodule

// File: rtl/lpf_pack.sv
module lpf_pack #(
   parameter int LANES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   input  logic [31:0]           push_dw,
   input  logic                  flush,
   output logic                  adv,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [LANES*32-1:0]   out_data,
   output logic [LANES*4-1:0]    out_be
);
   localparam int LANE_W = $clog2(LANES);

   logic [LANE_W-1:0] lane_q;
   logic              full_q;
   logic              pop;

   assign pop       = full_q && out_ready;
   assign adv       = !full_q || out_ready;
   assign out_valid = full_q;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [31:0] dat_q;
         logic        en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dat_q <= '0;
               en_q  <= 1'b0;
            end else if (push && lane_q == LANE_W'(l)) begin
               dat_q <= push_dw;
               en_q  <= 1'b1;
            end else if (pop) begin
               dat_q <= '0;
               en_q  <= 1'b0;
            end
         end
         assign out_data[32*l +: 32] = dat_q;
         assign out_be[4*l +: 4]     = {4{en_q}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (push)       lane_q <= lane_q + LANE_W'(1);
         else if (flush) lane_q <= '0;
         if ((push && lane_q == LANE_W'(LANES - 1)) || flush) full_q <= 1'b1;
         else if (pop)                                         full_q <= 1'b0;
      end
   end

endmodule

// File: rtl/lpf_link_framer.sv
module lpf_link_framer #(
   parameter int          OUT_BYTES   = 16,
   parameter logic [31:0] START_TOKEN = 32'h0000_A5F0,
   parameter logic [31:0] CRC_POLY    = 32'h04C1_1DB7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             cfg_align,
   input  logic                   tlp_valid,
   output logic                   tlp_ready,
   input  logic [31:0]            tlp_data,
   input  logic                   tlp_last,
   input  logic                   ctrl_valid,
   output logic                   ctrl_ready,
   input  logic [47:0]            ctrl_data,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [OUT_BYTES*8-1:0] out_data,
   output logic [OUT_BYTES-1:0]   out_be
);
   localparam int LANES = OUT_BYTES / 4;

   generate
      if (OUT_BYTES < 8 || (OUT_BYTES % 4) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
         $error("lpf_link_framer: OUT_BYTES must be a power of two of at least 8");
      end
      if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
         $error("lpf_link_framer: CRC_POLY must have its constant term set");
      end
   endgenerate

   logic        adv, push, flush, crc_clr, crc_en;
   logic [31:0] push_dw, crc_q;

   lpf_seq #(.LANES(LANES), .START_TOKEN(START_TOKEN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_align  (cfg_align),
      .tlp_valid  (tlp_valid),
      .tlp_ready  (tlp_ready),
      .tlp_data   (tlp_data),
      .tlp_last   (tlp_last),
      .ctrl_valid (ctrl_valid),
      .ctrl_ready (ctrl_ready),
      .ctrl_data  (ctrl_data),
      .adv        (adv),
      .crc_q      (crc_q),
      .crc_clr    (crc_clr),
      .crc_en     (crc_en),
      .push       (push),
      .push_dw    (push_dw),
      .flush      (flush)
   );

   lpf_crc32 #(.POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (tlp_data),
      .crc_q (crc_q)
   );

   lpf_pack #(.LANES(LANES)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_dw   (push_dw),
      .flush     (flush),
      .adv       (adv),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_be    (out_be)
   );

endmodule

// File: rtl/lpf_link_framer_chk.sv
module lpf_link_framer_chk #(
   parameter int OUT_BYTES = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tlp_valid,
   input logic                   tlp_ready,
   input logic                   tlp_last,
   input logic                   ctrl_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [OUT_BYTES*8-1:0] out_data,
   input logic [OUT_BYTES-1:0]   out_be
);
   localparam int LANES = OUT_BYTES / 4;

   logic                   in_pkt_q;
   logic [OUT_BYTES*8-1:0] be_bits;
   logic                   grain_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                in_pkt_q <= 1'b0;
      else if (tlp_valid && tlp_ready)           in_pkt_q <= !tlp_last;
   end

   always_comb begin
      grain_ok = 1'b1;
      for (int l = 0; l < LANES; l++)
         if (out_be[4*l +: 4] != 4'h0 && out_be[4*l +: 4] != 4'hF) grain_ok = 1'b0;
      for (int b = 0; b < OUT_BYTES; b++)
         be_bits[8*b +: 8] = {8{out_be[b]}};
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !tlp_ready && !ctrl_ready)); // R1

   AST_BE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_be != '0 && ((out_be + OUT_BYTES'(1)) & out_be) == '0)); // R8

   AST_BE_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> grain_ok); // R8

   AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data & ~be_bits) == '0); // R9

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be))); // R10

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tlp_ready && ctrl_ready)); // R7

   AST_CTL_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      in_pkt_q |-> !ctrl_ready); // R7

endmodule

bind lpf_link_framer lpf_link_framer_chk #(.OUT_BYTES(OUT_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tlp_valid  (tlp_valid),
   .tlp_ready  (tlp_ready),
   .tlp_last   (tlp_last),
   .ctrl_ready (ctrl_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_be     (out_be)
);

// File: tb/sim_lpf_link_framer.sv
`timescale 1ns/100ps
module sim_lpf_link_framer;

   localparam logic [31:0] STP  = 32'h0000_A5F0;
   localparam logic [31:0] POLY = 32'h04C1_1DB7;
   localparam int          MAXN = 2048;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cfg_align = 2'd0;
   logic         tlp_valid = 1'b0;
   logic         tlp_ready;
   logic [31:0]  tlp_data = '0;
   logic         tlp_last = 1'b0;
   logic         ctrl_valid = 1'b0;
   logic         ctrl_ready;
   logic [47:0]  ctrl_data = '0;
   logic         out_valid;
   logic         out_ready;
   logic [127:0] out_data;
   logic [15:0]  out_be;

   always #2.5 clk = ~clk;

   lpf_link_framer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_align(cfg_align),
      .tlp_valid(tlp_valid), .tlp_ready(tlp_ready), .tlp_data(tlp_data), .tlp_last(tlp_last),
      .ctrl_valid(ctrl_valid), .ctrl_ready(ctrl_ready), .ctrl_data(ctrl_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_be(out_be)
   );

   int          n_chk = 0, n_fail = 0;
   int          cyc = 0;
   bit          bp_on = 1'b0;
   int          align_dw = 0;
   logic [31:0] e_dw [0:MAXN-1];
   logic [3:0]  e_be [0:MAXN-1];
   logic [31:0] r_dw [0:MAXN-1];
   logic [3:0]  r_be [0:MAXN-1];
   int          e_n = 0, r_n = 0, e_pos = 0;

   // output side: choose ready for the coming edge, then record what it takes
   always @(negedge clk) begin
      cyc++;
      out_ready = bp_on ? ((cyc % 3) != 1) : 1'b1;
      if (rst_n && out_valid && out_ready) begin
         for (int l = 0; l < 4; l++) begin
            if (r_n < MAXN) begin
               r_dw[r_n] = out_data[32*l +: 32];
               r_be[r_n] = out_be[4*l +: 4];
               r_n++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int seed, input int i);
      return (32'(seed) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] pkt_crc(input int seed, input int n);
      logic [31:0] c = '1;
      logic [31:0] d;
      for (int i = 0; i < n; i++) begin
         d = pat(seed, i);
         for (int b = 0; b < 4; b++) begin
            c = c ^ {d[8*b +: 8], 24'h0};
            for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
         end
      end
      return ~c;
   endfunction

   // ---------------- expected stream model ----------------
   task automatic exp_push(input logic [31:0] dw, input logic [3:0] be);
      e_dw[e_n] = dw;
      e_be[e_n] = be;
      e_n++;
      e_pos = (e_pos + 1) % 16;
   endtask

   task automatic exp_tlp(input int seed, input int n, output int stp_idx);
      if (align_dw > 0)
         while ((e_pos % align_dw) != 0) exp_push(32'h0, 4'hF);
      stp_idx = e_n;
      exp_push(STP, 4'hF);
      for (int i = 0; i < n; i++) exp_push(pat(seed, i), 4'hF);
      exp_push(pkt_crc(seed, n), 4'hF);
   endtask

   task automatic exp_ctrl(input logic [47:0] d);
      exp_push(d[31:0], 4'hF);
      exp_push({16'h0, d[47:32]}, 4'hF);
   endtask

   // ---------------- drivers ----------------
   task automatic drive_tlp(input int seed, input int n, input bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 5) == 2) begin
            @(negedge clk);
            tlp_valid = 1'b0;
         end
         @(negedge clk);
         tlp_valid = 1'b1;
         tlp_data  = pat(seed, i);
         tlp_last  = (i == n - 1);
         #1;
         while (!tlp_ready) begin
            @(negedge clk);
            #1;
         end
      end
   endtask

   task automatic tlp_idle();
      @(negedge clk);
      tlp_valid = 1'b0;
      tlp_last  = 1'b0;
   endtask

   task automatic drive_ctrl(input logic [47:0] d);
      @(negedge clk);
      ctrl_valid = 1'b1;
      ctrl_data  = d;
      #1;
      while (!ctrl_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      ctrl_valid = 1'b0;
   endtask

   task automatic begin_scn(input logic [1:0] code, input bit bp);
      @(negedge clk);
      cfg_align = code;
      align_dw  = (code == 2'd0) ? 0 : (4 << (code - 1));
      bp_on     = bp;
      e_n       = 0;
      r_n       = 0;
   endtask

   task automatic end_scn(input string req);
      int bad;
      while ((e_pos % 4) != 0) exp_push(32'h0, 4'h0);
      for (int w = 0; w < 4000 && r_n < e_n; w++) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(r_n == e_n, req, "stream length", 64'(r_n), 64'(e_n));
      bad = -1;
      for (int i = 0; i < e_n && i < r_n; i++)
         if (bad < 0 && (r_dw[i] !== e_dw[i] || r_be[i] !== e_be[i])) bad = i;
      if (bad >= 0)
         chk(1'b0, req, $sformatf("stream dword %0d", bad),
             {28'h0, r_be[bad], r_dw[bad]}, {28'h0, e_be[bad], e_dw[bad]});
      else
         chk(1'b1, req, "stream content", 64'h0, 64'h0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(!out_valid, "R1", "out_valid in reset", 64'(out_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !tlp_ready && !ctrl_ready, "R1", "handshakes after reset",
          {61'h0, out_valid, tlp_ready, ctrl_ready}, 64'h0);
   endtask

   task automatic t_basic();
      int s;
      begin_scn(2'd0, 1'b0);
      exp_tlp(11, 7, s);
      drive_tlp(11, 7, 1'b0);
      tlp_idle();
      end_scn("R8");
      chk(r_dw[0] == STP && r_be[0] == 4'hF, "R2", "start token", 64'(r_dw[0]), 64'(STP));
      chk(r_dw[3] == pat(11, 2), "R3", "header dword 2", 64'(r_dw[3]), 64'(pat(11, 2)));
      chk(r_dw[8] == pkt_crc(11, 7), "R4", "link crc", 64'(r_dw[8]), 64'(pkt_crc(11, 7)));
      chk(r_be[9] == 4'h0 && r_dw[9] == 32'h0 && r_be[11] == 4'h0, "R9", "partial word tail",
          {r_be[9], r_dw[9]}, 64'h0);
   endtask

   task automatic t_align16();
      int s1, s2;
      begin_scn(2'd1, 1'b0);
      exp_tlp(21, 36, s1);
      exp_tlp(22, 67, s2);
      drive_tlp(21, 36, 1'b0);
      drive_tlp(22, 67, 1'b0);
      tlp_idle();
      end_scn("R5");
      chk(r_dw[s2] == STP && (s2 % 4) == 0, "R5", "second start token on 16B boundary",
          {32'(s2), r_dw[s2]}, {32'd40, STP});
      chk(r_dw[s2-1] == 32'h0 && r_be[s2-1] == 4'hF, "R5", "logical idle before token",
          {r_be[s2-1], r_dw[s2-1]}, 64'hF_0000_0000);
   endtask

   task automatic t_align_wide(input logic [1:0] code);
      int s1, s2;
      begin_scn(code, 1'b0);
      exp_tlp(31 + code, 4, s1);
      exp_tlp(41 + code, 9, s2);
      drive_tlp(31 + code, 4, 1'b0);
      drive_tlp(41 + code, 9, 1'b0);
      tlp_idle();
      end_scn("R5");
   endtask

   task automatic t_no_pad();
      int s1, s2;
      begin_scn(2'd0, 1'b0);
      exp_tlp(51, 4, s1);
      exp_tlp(52, 4, s2);
      drive_tlp(51, 4, 1'b0);
      drive_tlp(52, 4, 1'b0);
      tlp_idle();
      end_scn("R5");
      chk(r_dw[s1 + 6] == STP, "R5", "setting 0 packs back to back",
          64'(r_dw[s1 + 6]), 64'(STP));
   endtask

   task automatic t_ctrl();
      begin_scn(2'd1, 1'b0);
      exp_ctrl(48'h6655_4433_2211);
      drive_ctrl(48'h6655_4433_2211);
      end_scn("R6");
      chk(r_dw[0] == 32'h4433_2211 && r_dw[1] == 32'h0000_6655, "R6", "control slot layout",
          {r_dw[1], r_dw[0]}, 64'h0000_6655_4433_2211);
   endtask

   task automatic t_priority();
      int s;
      begin_scn(2'd0, 1'b0);
      exp_ctrl(48'hABCD_0123_4567);
      exp_tlp(61, 5, s);
      fork
         drive_ctrl(48'hABCD_0123_4567);
         begin
            drive_tlp(61, 5, 1'b0);
            tlp_idle();
         end
      join
      end_scn("R7");
      chk(r_dw[0] == 32'h0123_4567 && r_dw[2] == STP, "R7", "control before waiting packet",
          {r_dw[2], r_dw[0]}, {STP, 32'h0123_4567});
   endtask

   task automatic t_ctrl_mid();
      int s1, s2;
      begin_scn(2'd1, 1'b0);
      exp_tlp(71, 36, s1);
      exp_ctrl(48'h1111_2222_3333);
      exp_tlp(72, 5, s2);
      fork
         begin
            drive_tlp(71, 36, 1'b0);
            drive_tlp(72, 5, 1'b0);
            tlp_idle();
         end
         begin
            repeat (6) @(negedge clk);
            drive_ctrl(48'h1111_2222_3333);
         end
      join
      end_scn("R7");
      chk(r_dw[s1 + 38] == 32'h2222_3333, "R7", "control right after link crc",
          64'(r_dw[s1 + 38]), 64'h2222_3333);
   endtask

   task automatic t_backpressure();
      int s1, s2;
      begin_scn(2'd2, 1'b1);
      exp_tlp(81, 132, s1);
      exp_ctrl(48'h0F0E_0D0C_0B0A);
      exp_tlp(82, 19, s2);
      fork
         begin
            drive_tlp(81, 132, 1'b0);
            drive_tlp(82, 19, 1'b0);
            tlp_idle();
         end
         begin
            repeat (20) @(negedge clk);
            drive_ctrl(48'h0F0E_0D0C_0B0A);
         end
      join
      end_scn("R10");
      bp_on = 1'b0;
   endtask

   task automatic t_stall();
      int s;
      begin_scn(2'd0, 1'b0);
      exp_tlp(91, 23, s);
      drive_tlp(91, 23, 1'b1);
      tlp_idle();
      end_scn("R11");
   endtask

   task automatic t_max();
      int s;
      begin_scn(2'd3, 1'b0);
      exp_tlp(101, 260, s);
      drive_tlp(101, 260, 1'b0);
      tlp_idle();
      end_scn("R3");
      chk(r_dw[s + 261] == pkt_crc(101, 260), "R4", "crc of 1024-byte payload",
          64'(r_dw[s + 261]), 64'(pkt_crc(101, 260)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_align16();
      t_align_wide(2'd2);
      t_align_wide(2'd3);
      t_no_pad();
      t_ctrl();
      t_priority();
      t_ctrl_mid();
      t_backpressure();
      t_stall();
      t_max();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule